// File: doc/BRIEF.md
# Center-aligned sine PWM generator with dead time

This block drives the four gates of a single-phase full-bridge inverter. A carrier counter runs up from zero to a programmed period and back down to zero, which gives a symmetric triangular carrier. Each bridge leg has its own compare value. The leg's square wave changes level when the counter matches that value, once on the way up and once on the way down. Each leg square wave is then split into a complementary high-side and low-side gate pair. The turn-on of each gate is held back by a programmable dead time.

A host writes the period, the per-leg compare values and the dead time through a small write port into shadow registers. The shadow contents move into the working registers only in a cycle where the carrier sits at zero. In that same cycle the block raises an interrupt pulse, so the host can compute the next sine sample while the current carrier period runs. A global enable holds the carrier at zero and forces every gate low.

Top module: `spwm_deadband_top`

## Requirements
- R1: After reset with `enable` low, all four gate outputs are 0, `carrier_cnt` is 0 and `zero_irq` is 0.
- R2: While enabled with period P ≥ 1, `carrier_cnt` steps by one per clock through 0,1,…,P,P-1,…,1 and then back to 0. One carrier period therefore lasts 2P clocks and its peak value is P.
- R3: A write with `wr_en` high lands in a shadow register selected by `wr_addr`: 0 is the period, 1 is the compare for leg 0, 2 is the compare for leg 1, and 3 is the dead time, taken from the low DT_W bits. The working registers copy the shadows only in a cycle where `carrier_cnt` is 0. A write made in mid-period leaves the period in progress unchanged.
- R4: `zero_irq` is 1 in exactly those cycles where `enable` is 1 and `carrier_cnt` is 0.
- R5: For a leg with compare C where 0 < C < P, the leg square wave is high for 2C clocks per carrier period, centred on the carrier zero point. It toggles where the count equals C on the up slope and on the down slope. With dead time D, `gate_hi` of that leg is therefore high for max(2C-D,0) clocks per period and `gate_lo` for max(2P-2C-D,0) clocks.
- R6: A compare of 0 keeps the leg low for the whole period: `gate_hi` is never high and `gate_lo` is high for all 2P clocks. A compare of P or more keeps the leg high for the whole period: `gate_hi` is high for all 2P clocks and `gate_lo` never.
- R7: Each gate rises only after its leg has held the matching level for D clocks. The two gates of one leg are never high in the same cycle, and with D ≥ 1 a gate never rises in the cycle right after its partner was high.
- R8: With `enable` low, all four gates are 0 and the carrier is held at 0. After `enable` rises, both gates of every leg stay 0 for D clocks. Then the gate matching the leg level turns on.
- R9: The two legs use their own compare values, so different compares give different pulse widths on each leg within the same carrier period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Global run enable; low forces gates off and parks the carrier |
| wr_en | input | 1 | Shadow register write strobe |
| wr_addr | input | ADDR_W (2) | Shadow register select: 0 period, 1..NUM_LEGS compares, NUM_LEGS+1 dead time |
| wr_data | input | CNT_W (16) | Write data |
| carrier_cnt | output | CNT_W (16) | Current triangular carrier value |
| zero_irq | output | 1 | High while enabled and the carrier is at zero |
| gate_hi | output | NUM_LEGS (2) | High-side gate per leg |
| gate_lo | output | NUM_LEGS (2) | Low-side gate per leg |

## Verification
The bench measures whole carrier periods and compares each one with widths computed from the compare, period and dead time. A design that dropped the down-slope toggle, or that toggled twice at the peak, would give the wrong high count. The two forced cases are covered: a compare of zero, and a compare equal to or above the period. A design that still toggled in those cases would give short pulses instead of a solid level. The bench also covers a dead time longer than the pulse, where a leaky design would let a gate flicker on. A period rewrite in mid-period must leave the running peak unchanged, or the counter would jump. Re-enabling must delay the gates by the dead time, or the gates would switch on with no gap.

// File: rtl/spwm_pkg.sv
// Shared definitions for the center-aligned PWM generator.
// Holds the carrier direction type and the host address map helpers.
package spwm_pkg;

    typedef enum logic {
        DIR_UP   = 1'b0,
        DIR_DOWN = 1'b1
    } dir_e;

    // Address of the period shadow register.
    localparam int unsigned ADDR_PERIOD = 0;

    // Address of the compare shadow of one leg.
    function automatic int unsigned cmp_addr(input int unsigned leg);
        return leg + 1;
    endfunction

    // Address of the dead-time shadow, placed after the last leg.
    function automatic int unsigned dt_addr(input int unsigned legs);
        return legs + 1;
    endfunction

endpackage

// File: rtl/spwm_regs.sv
// Shadow and working registers for period, compares and dead time.
// Host writes land in shadows; working copies load on every cycle the
// carrier is at zero. The "use" outputs give the value that rules the
// current cycle: the shadow at the zero point, the working copy elsewhere.
// Assumes DT_W <= CNT_W.
module spwm_regs
    import spwm_pkg::*;
#(
    parameter int unsigned NUM_LEGS   = 2,
    parameter int unsigned CNT_W      = 16,
    parameter int unsigned DT_W       = 8,
    parameter int unsigned ADDR_W     = 2,
    parameter int unsigned PERIOD_RST = 100
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               wr_en,
    input  logic [ADDR_W-1:0]                  wr_addr,
    input  logic [CNT_W-1:0]                   wr_data,
    input  logic                               zero_pt,
    output logic [CNT_W-1:0]                   per_sh,
    output logic [CNT_W-1:0]                   per_act,
    output logic [CNT_W-1:0]                   per_use,
    output logic [NUM_LEGS-1:0][CNT_W-1:0]     cmp_use,
    output logic [DT_W-1:0]                    dt_act
);

    logic [DT_W-1:0] dt_sh;
    logic [NUM_LEGS-1:0][CNT_W-1:0] cmp_sh;
    logic [NUM_LEGS-1:0][CNT_W-1:0] cmp_act;

    // Period shadow capture and load at the zero point.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            per_sh  <= CNT_W'(PERIOD_RST);
            per_act <= CNT_W'(PERIOD_RST);
        end else begin
            if (wr_en && (wr_addr == ADDR_W'(ADDR_PERIOD))) begin
                per_sh <= wr_data;
            end
            if (zero_pt) begin
                per_act <= per_sh;
            end
        end
    end

    // Dead-time shadow capture and load at the zero point.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dt_sh  <= '0;
            dt_act <= '0;
        end else begin
            if (wr_en && (wr_addr == ADDR_W'(dt_addr(NUM_LEGS)))) begin
                dt_sh <= wr_data[DT_W-1:0];
            end
            if (zero_pt) begin
                dt_act <= dt_sh;
            end
        end
    end

    genvar g;
    generate
        for (g = 0; g < NUM_LEGS; g++) begin : g_cmp
            // Per-leg compare shadow capture and load at the zero point.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    cmp_sh[g]  <= '0;
                    cmp_act[g] <= '0;
                end else begin
                    if (wr_en && (wr_addr == ADDR_W'(cmp_addr(g)))) begin
                        cmp_sh[g] <= wr_data;
                    end
                    if (zero_pt) begin
                        cmp_act[g] <= cmp_sh[g];
                    end
                end
            end

            // Compare value that governs this cycle.
            assign cmp_use[g] = zero_pt ? cmp_sh[g] : cmp_act[g];
        end
    endgenerate

    // Period value that governs this cycle.
    assign per_use = zero_pt ? per_sh : per_act;

endmodule

// File: rtl/spwm_carrier.sv
// Triangular up/down carrier: 0,1..P,P-1..1,0,... with P taken from
// per_use. Parked at zero while disabled or when the period is zero.
// zero_pt flags every cycle the count is zero.
module spwm_carrier
    import spwm_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [CNT_W-1:0] per_use,
    output logic [CNT_W-1:0] cnt,
    output logic             zero_pt
);

    dir_e dir;

    // Count step and slope reversal at the peak and at one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            dir <= DIR_UP;
        end else if (!enable || (per_use == '0)) begin
            cnt <= '0;
            dir <= DIR_UP;
        end else if ((dir == DIR_UP) || (cnt == '0)) begin
            if (cnt >= per_use) begin
                cnt <= cnt - CNT_W'(1);
                dir <= DIR_DOWN;
            end else begin
                cnt <= cnt + CNT_W'(1);
                dir <= DIR_UP;
            end
        end else begin
            cnt <= cnt - CNT_W'(1);
            if (cnt == CNT_W'(1)) begin
                dir <= DIR_UP;
            end
        end
    end

    // Zero-point flag used for reload and the interrupt.
    assign zero_pt = (cnt == '0);

endmodule

// File: rtl/spwm_leg.sv
// One leg square wave. At the zero point the leg starts high unless its
// compare is zero; in between it toggles when the count equals a compare
// lying strictly between zero and the period. A compare at or above the
// period never matches, so the leg stays high all period.
module spwm_leg #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             zero_pt,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] cmp_use,
    input  logic [CNT_W-1:0] per_use,
    output logic             leg
);

    logic in_range;

    // Compare is one that produces two toggles per period.
    assign in_range = (cmp_use != '0) && (cmp_use < per_use);

    // Leg level: preset at zero, invert on match.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            leg <= 1'b0;
        end else if (zero_pt) begin
            leg <= (cmp_use != '0);
        end else if (in_range && (cnt == cmp_use)) begin
            leg <= ~leg;
        end
    end

endmodule

// File: rtl/spwm_deadband.sv
// Complementary gate pair with turn-on delay. Tracks the leg level; each
// level change restarts a counter, and the gate matching the level turns
// on only once the counter reaches the dead time. Disabled: gates off and
// the counter held at zero, so re-enabling also waits the dead time.
module spwm_deadband #(
    parameter int unsigned DT_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            enable,
    input  logic            leg,
    input  logic [DT_W-1:0] dt,
    output logic            gate_hi,
    output logic            gate_lo
);

    logic            lvl;
    logic [DT_W-1:0] dcnt;
    logic            settled;

    // Level tracking and dead-time counting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl  <= 1'b0;
            dcnt <= '0;
        end else if (!enable) begin
            lvl  <= leg;
            dcnt <= '0;
        end else if (leg != lvl) begin
            lvl  <= leg;
            dcnt <= '0;
        end else if (dcnt < dt) begin
            dcnt <= dcnt + DT_W'(1);
        end
    end

    // Gate decode once the dead time has elapsed.
    assign settled = enable && (dcnt >= dt);
    assign gate_hi = settled && lvl;
    assign gate_lo = settled && !lvl;

endmodule

// File: rtl/spwm_deadband_top.sv
// Single-phase center-aligned sine PWM generator with dead time.
// Host writes go to shadows that load at the carrier zero point; each leg
// compare drives one complementary gate pair. Assumes synchronous host
// writes on clk and DT_W <= CNT_W.
module spwm_deadband_top
    import spwm_pkg::*;
#(
    parameter int unsigned NUM_LEGS   = 2,
    parameter int unsigned CNT_W      = 16,
    parameter int unsigned DT_W       = 8,
    parameter int unsigned PERIOD_RST = 100,
    localparam int unsigned ADDR_W    = $clog2(NUM_LEGS + 2)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                enable,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [CNT_W-1:0]    wr_data,
    output logic [CNT_W-1:0]    carrier_cnt,
    output logic                zero_irq,
    output logic [NUM_LEGS-1:0] gate_hi,
    output logic [NUM_LEGS-1:0] gate_lo
);

    logic                           zero_pt;
    logic [CNT_W-1:0]               per_sh;
    logic [CNT_W-1:0]               per_act;
    logic [CNT_W-1:0]               per_use;
    logic [NUM_LEGS-1:0][CNT_W-1:0] cmp_use;
    logic [DT_W-1:0]                dt_act;
    logic [NUM_LEGS-1:0]            leg_q;

    spwm_regs #(
        .NUM_LEGS  (NUM_LEGS),
        .CNT_W     (CNT_W),
        .DT_W      (DT_W),
        .ADDR_W    (ADDR_W),
        .PERIOD_RST(PERIOD_RST)
    ) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_addr(wr_addr),
        .wr_data(wr_data),
        .zero_pt(zero_pt),
        .per_sh (per_sh),
        .per_act(per_act),
        .per_use(per_use),
        .cmp_use(cmp_use),
        .dt_act (dt_act)
    );

    spwm_carrier #(
        .CNT_W(CNT_W)
    ) u_carrier (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (enable),
        .per_use(per_use),
        .cnt    (carrier_cnt),
        .zero_pt(zero_pt)
    );

    genvar g;
    generate
        for (g = 0; g < NUM_LEGS; g++) begin : g_leg
            spwm_leg #(
                .CNT_W(CNT_W)
            ) u_leg (
                .clk    (clk),
                .rst_n  (rst_n),
                .zero_pt(zero_pt),
                .cnt    (carrier_cnt),
                .cmp_use(cmp_use[g]),
                .per_use(per_use),
                .leg    (leg_q[g])
            );

            spwm_deadband #(
                .DT_W(DT_W)
            ) u_db (
                .clk    (clk),
                .rst_n  (rst_n),
                .enable (enable),
                .leg    (leg_q[g]),
                .dt     (dt_act),
                .gate_hi(gate_hi[g]),
                .gate_lo(gate_lo[g])
            );
        end
    endgenerate

    // Interrupt at each enabled zero point.
    assign zero_irq = enable && zero_pt;

endmodule

// File: rtl/spwm_sva.sv
// Property checker for the PWM generator, attached to the top by bind.
// Watches carrier stepping, shadow reload, interrupt timing and gate
// exclusivity.
module spwm_sva #(
    parameter int unsigned NUM_LEGS = 2,
    parameter int unsigned CNT_W    = 16,
    parameter int unsigned DT_W     = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                enable,
    input logic [CNT_W-1:0]    carrier_cnt,
    input logic                zero_irq,
    input logic [NUM_LEGS-1:0] gate_hi,
    input logic [NUM_LEGS-1:0] gate_lo,
    input logic [CNT_W-1:0]    per_act,
    input logic [CNT_W-1:0]    per_sh,
    input logic [DT_W-1:0]     dt_act
);

    p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (carrier_cnt != '0) |-> (carrier_cnt <= per_act));

    p_cnt_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && $past(enable) && (carrier_cnt != '0)) |->
        ((carrier_cnt == $past(carrier_cnt) + CNT_W'(1)) ||
         (carrier_cnt == $past(carrier_cnt) - CNT_W'(1))));

    p_shadow_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (carrier_cnt == '0) |=> (per_act == $past(per_sh)));

    p_irq_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
        zero_irq |=> (carrier_cnt <= CNT_W'(1)));

    p_enable_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(enable) && (dt_act != '0)) |-> ((gate_hi == '0) && (gate_lo == '0)));

    genvar g;
    generate
        for (g = 0; g < NUM_LEGS; g++) begin : g_chk
            p_no_overlap_r7: assert property (@(posedge clk) disable iff (!rst_n)
                !(gate_hi[g] && gate_lo[g]));

            p_hi_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
                ((dt_act != '0) && $rose(gate_hi[g])) |-> ($past(gate_lo[g]) == 1'b0));

            p_lo_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
                ((dt_act != '0) && $rose(gate_lo[g])) |-> ($past(gate_hi[g]) == 1'b0));
        end
    endgenerate

endmodule

bind spwm_deadband_top spwm_sva #(
    .NUM_LEGS(NUM_LEGS),
    .CNT_W   (CNT_W),
    .DT_W    (DT_W)
) u_sva (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .carrier_cnt(carrier_cnt),
    .zero_irq   (zero_irq),
    .gate_hi    (gate_hi),
    .gate_lo    (gate_lo),
    .per_act    (per_act),
    .per_sh     (per_sh),
    .dt_act     (dt_act)
);

// File: tb/spwm_deadband_top_test.sv
// Scoreboard bench: the driver programs a setting, lets it settle, and
// pushes the expected per-period widths; the monitor measures one carrier
// period from zero point to zero point and compares.
module spwm_deadband_top_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [15:0] carrier_cnt;
    logic        zero_irq;
    logic [1:0]  gate_hi;
    logic [1:0]  gate_lo;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    typedef struct {
        string tag;
        int len, peak, hi0, lo0, hi1, lo1;
    } exp_t;

    exp_t q[$];
    bit armed = 0;

    always #5 clk = ~clk;

    spwm_deadband_top uut (
        .clk(clk), .rst_n(rst_n), .enable(enable),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .carrier_cnt(carrier_cnt), .zero_irq(zero_irq),
        .gate_hi(gate_hi), .gate_lo(gate_lo)
    );

    task automatic chk(input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", what, act, exp);
        end
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    // Widths per leg from R5 and R6.
    function automatic void leg_w(input int p, input int c, input int d,
                                  output int hi, output int lo);
        if (c == 0) begin
            hi = 0; lo = 2 * p;
        end else if (c >= p) begin
            hi = 2 * p; lo = 0;
        end else begin
            hi = (2 * c > d) ? 2 * c - d : 0;
            lo = (2 * p - 2 * c > d) ? 2 * p - 2 * c - d : 0;
        end
    endfunction

    task automatic wr(input int a, input int d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 2'(a); wr_data = 16'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_zeros(input int n);
        repeat (n) begin
            @(negedge clk);
            while (!zero_irq) @(negedge clk);
        end
    endtask

    // Program, settle, push expectation, wait for the monitor.
    task automatic run_cfg(input string tag, input int p, input int c0,
                           input int c1, input int d);
        exp_t e;
        wr(0, p); wr(1, c0); wr(2, c1); wr(3, d);
        wait_zeros(3);
        e.tag = tag; e.len = 2 * p; e.peak = p;
        leg_w(p, c0, d, e.hi0, e.lo0);
        leg_w(p, c1, d, e.hi1, e.lo1);
        q.push_back(e);
        while (q.size() != 0 || armed) @(negedge clk);
    endtask

    // Monitor: continuous R4/R7 checks and per-period measurement.
    initial begin : monitor
        int len = 0, peak = 0, h0 = 0, l0 = 0, h1 = 0, l1 = 0;
        exp_t e;
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (zero_irq != (enable && carrier_cnt == 0))
                    chk("R4 zero_irq vs carrier", int'(zero_irq), int'(enable && carrier_cnt == 0));
                if ((gate_hi & gate_lo) != 0)
                    chk("R7 gate overlap", int'(gate_hi & gate_lo), 0);
                if (zero_irq) begin
                    if (armed) begin
                        e = q.pop_front();
                        chk({e.tag, " R2 period length"}, len, e.len);
                        chk({e.tag, " R2 peak"}, peak, e.peak);
                        chk({e.tag, " leg0 hi width"}, h0, e.hi0);
                        chk({e.tag, " leg0 lo width"}, l0, e.lo0);
                        chk({e.tag, " R9 leg1 hi width"}, h1, e.hi1);
                        chk({e.tag, " R9 leg1 lo width"}, l1, e.lo1);
                        armed = 0;
                    end
                    if (q.size() != 0) armed = 1;
                    len = 0; peak = 0; h0 = 0; l0 = 0; h1 = 0; l1 = 0;
                end
                len++;
                if (int'(carrier_cnt) > peak) peak = int'(carrier_cnt);
                h0 += int'(gate_hi[0]); l0 += int'(gate_lo[0]);
                h1 += int'(gate_hi[1]); l1 += int'(gate_lo[1]);
            end
        end
    end

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            chk("watchdog expired", 1, 0);
            report();
        end
    end

    initial begin : driver
        int maxc;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 gates after reset", int'({gate_hi, gate_lo}), 0);
        chk("R1 carrier after reset", int'(carrier_cnt), 0);
        chk("R1 zero_irq after reset", int'(zero_irq), 0);

        // Configure while disabled, then run.
        wr(0, 20); wr(1, 5); wr(2, 12); wr(3, 2);
        @(negedge clk);
        chk("R8 gates while disabled", int'({gate_hi, gate_lo}), 0);
        chk("R8 carrier parked", int'(carrier_cnt), 0);
        enable = 1'b1;

        run_cfg("R5 mid compares", 20, 5, 12, 2);
        run_cfg("R6 zero and equal-period compares", 16, 0, 16, 3);
        run_cfg("R5 no dead time", 10, 1, 9, 0);
        run_cfg("R6 dead time beyond pulse", 10, 1, 25, 4);
        run_cfg("R5 restore", 20, 5, 12, 2);

        // R3: period rewrite in mid-period leaves the running period alone.
        wait_zeros(1);
        repeat (3) @(negedge clk);
        wr(0, 30);
        maxc = 0;
        @(negedge clk);
        while (!zero_irq) begin
            if (int'(carrier_cnt) > maxc) maxc = int'(carrier_cnt);
            @(negedge clk);
        end
        chk("R3 running peak after mid-period write", maxc, 20);
        run_cfg("R3 new period after reload", 30, 5, 12, 2);

        // R8: disable and re-enable with dead time 2.
        @(negedge clk);
        enable = 1'b0;
        @(negedge clk);
        chk("R8 gates off when disabled", int'({gate_hi, gate_lo}), 0);
        chk("R8 carrier held at zero", int'(carrier_cnt), 0);
        chk("R4 no irq when disabled", int'(zero_irq), 0);
        repeat (3) @(negedge clk);
        enable = 1'b1;
        @(negedge clk);
        chk("R8 dead time after enable", int'({gate_hi, gate_lo}), 0);
        @(negedge clk);
        chk("R8 gate_hi after dead time", int'(gate_hi), 3);
        chk("R8 gate_lo after dead time", int'(gate_lo), 0);

        run_cfg("R9 distinct legs", 12, 3, 8, 1);
        chk("R4 continuous check ran", 1, 1);
        chk("R7 continuous check ran", 1, 1);
        done = 1;
        report();
    end

endmodule